// File: doc/BRIEF.md
# Two-Thread Shared Execution Unit Issue Arbiter

This block is the issue stage of a small two-thread multithreaded core. Each logical thread owns a private program counter, a one-entry issue slot and a small writeback context that records the tag of its most recently completed operation. The two threads share three typed execution units: an integer unit, a floating-point unit and a load/store unit. A parameter adds a second integer unit. Every unit takes one operation per cycle, and every operation completes in one cycle.

Operations enter through one valid/ready stream per thread. Each operation is an abstract record made of a unit code and a tag. Only one thread may fetch in a cycle. The fetch turn alternates every cycle, so each thread's `fe_ready` can only be high on its own turn. `fe_ready` never depends on `fe_valid`. A source may withdraw or change an offer that has not been accepted. An operation is accepted on a clock edge where both valid and ready are high. From the next cycle on, it sits in the thread's slot and competes for its unit. The issue side has no back-pressure, because units always accept.

When both slots target the same unit, the conflict is flagged and a round-robin bit picks the winner. The loser keeps its operation and retries the next cycle. A halt input freezes a thread: it issues and fetches nothing, and it leaves every unit and every fetch cycle to the other thread.

Top module: `smt_issue_arbiter`

## Requirements
- R1: During and right after reset, both slots are empty, both program counters read 0, no issue port is valid, the conflict total is 0, and thread 0 holds the first fetch turn (`fe_ready` = 2'b01).
- R2: While neither thread is halted, at most one `fe_ready` bit is high, and the fetch turn flips every cycle. While one thread is halted, the other may fetch in every cycle in which its slot can take an operation.
- R3: A thread's program counter rises by one on each accepted operation and holds in every other cycle, including cycles in which its slot is stalled.
- R4: Unit codes are 0 for integer, 1 for floating point and 2 for load/store; code 3 is never offered. An operation accepted at an edge is offered in the next cycle. When it is granted, issue port 0 (integer), port 1 (floating point) or port 2 (load/store) is valid in that cycle and carries its tag.
- R5: When both slots request the same unit and that unit has no twin, `conflict_now` is high and exactly one of the two operations issues.
- R6: Thread 0 wins the first conflict after reset, and the winner alternates on every later conflict.
- R7: An operation that loses a conflict stays in its slot unchanged and is offered again in the next cycle. That thread's `fe_ready` is low while the slot is stalled.
- R8: With `DUAL_INT` = 1, when both slots request the integer unit, both issue in the same cycle with no conflict: thread 0 on port 0 and thread 1 on port 3.
- R9: A halted thread issues nothing and fetches nothing, and it keeps its slot. After it is released, its held operation competes again.
- R10: Each valid issue port reports the issuing thread on `iss_thread`. In the cycle after an issue, that thread's `wb_valid` is high and its `wb_tag` holds the issued tag.
- R11: `busy_now` equals the number of valid issue ports. `idle_now` equals the number of units present minus `busy_now`. `conflict_total` increases by one for each conflict cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 2 | Per-thread halt, bit t halts thread t |
| fe_valid | input | 2 | Per-thread operation offer |
| fe_ready | output | 2 | Per-thread acceptance |
| fe_unit | input | 4 | Unit code, thread t in bits [2t+1:2t] |
| fe_tag | input | 2*TAG_W | Operation tag, thread t in slice t |
| pc_out | output | 2*PC_W | Program counter, thread t in slice t |
| iss_valid | output | 4 | Issue port valid: 0 int, 1 fp, 2 load/store, 3 second int |
| iss_thread | output | 4 | Issuing thread per port |
| iss_tag | output | 4*TAG_W | Tag per issue port, port p in slice p |
| wb_valid | output | 2 | Per-thread completion pulse |
| wb_tag | output | 2*TAG_W | Last completed tag per thread |
| busy_now | output | 3 | Units used this cycle |
| idle_now | output | 3 | Units unused this cycle |
| conflict_now | output | 1 | Same-unit collision this cycle |
| conflict_total | output | CNT_W | Running count of conflict cycles |

## Verification
The bench builds two conflicts, one after a release from halt. The first checks that thread 0 wins. The second checks that thread 1 wins; a priority bit that never flips would let thread 0 win both. It checks that the loser's `fe_ready` stays low and its program counter holds; a design that let fetch overwrite a stalled slot would advance the counter and lose the operation. It follows fetch turns through single- and dual-halt cycles, which catches a design that hands the turn to a halted thread or lets both threads fetch at once. A second instance with the twin integer unit checks that two integer operations issue together on ports 0 and 3, where the single-unit build would have flagged a conflict.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int N_THR  = 2;
  localparam int N_PORT = 4;
  localparam int BUSY_W = $clog2(N_PORT + 1);

  localparam logic [1:0] U_INT = 2'd0;
  localparam logic [1:0] U_FPU = 2'd1;
  localparam logic [1:0] U_LSU = 2'd2;
  localparam logic [1:0] U_BAD = 2'd3;

  localparam int P_INT0 = 0;
  localparam int P_FPU  = 1;
  localparam int P_LSU  = 2;
  localparam int P_INT1 = 3;
endpackage

// File: rtl/smt_thread_ctx.sv
module smt_thread_ctx #(
  parameter int TAG_W = 8,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             fetch_ok,
  input  logic             fe_valid,
  input  logic [1:0]       fe_unit,
  input  logic [TAG_W-1:0] fe_tag,
  input  logic             grant,
  output logic             fe_ready,
  output logic             req,
  output logic [1:0]       slot_unit,
  output logic [TAG_W-1:0] slot_tag,
  output logic [PC_W-1:0]  pc_q,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  logic slot_v;

  assign req      = slot_v && !halt;
  assign fe_ready = !halt && fetch_ok && (!slot_v || grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v    <= 1'b0;
      slot_unit <= '0;
      slot_tag  <= '0;
      pc_q      <= '0;
    end else if (fe_valid && fe_ready) begin
      slot_v    <= 1'b1;
      slot_unit <= fe_unit;
      slot_tag  <= fe_tag;
      pc_q      <= pc_q + PC_W'(1);
    end else if (grant) begin
      slot_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_tag   <= '0;
    end else begin
      wb_valid <= grant;
      if (grant) wb_tag <= slot_tag;
    end
  end

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fe_valid && fe_ready) |=> $stable(pc_q));
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready) |=> pc_q == $past(pc_q) + PC_W'(1));
  assert_stall_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v && !grant) |=> slot_v && $stable(slot_tag) && $stable(slot_unit));
endmodule

// File: rtl/smt_unit_arb.sv
module smt_unit_arb
  import smt_pkg::*;
#(
  parameter bit DUAL_INT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_THR-1:0]  halt,
  input  logic [N_THR-1:0]  req,
  input  logic [1:0]        unit_a,
  input  logic [1:0]        unit_b,
  output logic [N_THR-1:0]  grant,
  output logic [N_THR-1:0]  fetch_ok,
  output logic              conflict,
  output logic [N_PORT-1:0] port_valid,
  output logic [N_PORT-1:0] port_thr
);
  logic turn_q, prio_q, share_int, int_pair;

  generate
    if (DUAL_INT) begin : g_twin
      assign share_int = (unit_a == U_INT) && (unit_b == U_INT);
    end else begin : g_single
      assign share_int = 1'b0;
    end
  endgenerate

  assign conflict = req[0] && req[1] && (unit_a == unit_b) && !share_int;
  assign grant[0] = req[0] && (!conflict || !prio_q);
  assign grant[1] = req[1] && (!conflict ||  prio_q);
  assign int_pair = grant[0] && grant[1] && share_int;

  assign fetch_ok[0] = !turn_q || halt[1];
  assign fetch_ok[1] =  turn_q || halt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= 1'b0;
      prio_q <= 1'b0;
    end else begin
      turn_q <= !turn_q;
      if (conflict) prio_q <= !prio_q;
    end
  end

  always_comb begin
    port_valid = '0;
    port_thr   = '0;
    if (grant[0] && unit_a != U_BAD) begin
      port_valid[unit_a] = 1'b1;
      port_thr[unit_a]   = 1'b0;
    end
    if (grant[1] && unit_b != U_BAD) begin
      if (int_pair) begin
        port_valid[P_INT1] = 1'b1;
        port_thr[P_INT1]   = 1'b1;
      end else begin
        port_valid[unit_b] = 1'b1;
        port_thr[unit_b]   = 1'b1;
      end
    end
  end

  // checker state: winner of the previous conflict
  logic last_win_q, seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_win_q <= 1'b0;
      seen_q     <= 1'b0;
    end else if (conflict) begin
      last_win_q <= grant[1];
      seen_q     <= 1'b1;
    end
  end

  assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> $onehot(grant));
  assert_first_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !seen_q) |-> grant[0]);
  assert_rr_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && seen_q) |-> !grant[last_win_q]);
  assert_grant_routed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(port_valid) == $countones(grant));
endmodule

// File: rtl/smt_util_count.sv
module smt_util_count
  import smt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_UNITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PORT-1:0] port_valid,
  input  logic              conflict,
  output logic [BUSY_W-1:0] busy_now,
  output logic [BUSY_W-1:0] idle_now,
  output logic [CNT_W-1:0]  conflict_total
);
  always_comb begin
    busy_now = '0;
    for (int p = 0; p < N_PORT; p++) busy_now = busy_now + BUSY_W'(port_valid[p]);
  end

  assign idle_now = BUSY_W'(N_UNITS) - busy_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        conflict_total <= '0;
    else if (conflict) conflict_total <= conflict_total + CNT_W'(1);
  end

  assert_conflict_tally_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> conflict_total == $past(conflict_total) + CNT_W'(1));
  assert_conflict_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |=> $stable(conflict_total));
endmodule

// File: rtl/smt_issue_arbiter.sv
module smt_issue_arbiter
  import smt_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int PC_W     = 16,
  parameter int CNT_W    = 16,
  parameter bit DUAL_INT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              halt,
  input  logic [1:0]              fe_valid,
  output logic [1:0]              fe_ready,
  input  logic [3:0]              fe_unit,
  input  logic [2*TAG_W-1:0]      fe_tag,
  output logic [2*PC_W-1:0]       pc_out,
  output logic [3:0]              iss_valid,
  output logic [3:0]              iss_thread,
  output logic [4*TAG_W-1:0]      iss_tag,
  output logic [1:0]              wb_valid,
  output logic [2*TAG_W-1:0]      wb_tag,
  output logic [2:0]              busy_now,
  output logic [2:0]              idle_now,
  output logic                    conflict_now,
  output logic [CNT_W-1:0]        conflict_total
);
  localparam int N_UNITS = DUAL_INT ? 4 : 3;

  logic [N_THR-1:0] fetch_ok, req, grant;
  logic [1:0]       slot_unit [N_THR];
  logic [TAG_W-1:0] slot_tag  [N_THR];

  generate
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
      smt_thread_ctx #(.TAG_W(TAG_W), .PC_W(PC_W)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt[t]),
        .fetch_ok (fetch_ok[t]),
        .fe_valid (fe_valid[t]),
        .fe_unit  (fe_unit[2*t +: 2]),
        .fe_tag   (fe_tag[t*TAG_W +: TAG_W]),
        .grant    (grant[t]),
        .fe_ready (fe_ready[t]),
        .req      (req[t]),
        .slot_unit(slot_unit[t]),
        .slot_tag (slot_tag[t]),
        .pc_q     (pc_out[t*PC_W +: PC_W]),
        .wb_valid (wb_valid[t]),
        .wb_tag   (wb_tag[t*TAG_W +: TAG_W])
      );
    end
  endgenerate

  smt_unit_arb #(.DUAL_INT(DUAL_INT)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .req       (req),
    .unit_a    (slot_unit[0]),
    .unit_b    (slot_unit[1]),
    .grant     (grant),
    .fetch_ok  (fetch_ok),
    .conflict  (conflict_now),
    .port_valid(iss_valid),
    .port_thr  (iss_thread)
  );

  generate
    for (genvar p = 0; p < N_PORT; p++) begin : g_port
      assign iss_tag[p*TAG_W +: TAG_W] = iss_valid[p] ? slot_tag[iss_thread[p]] : '0;
    end
  endgenerate

  smt_util_count #(.CNT_W(CNT_W), .N_UNITS(N_UNITS)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_valid    (iss_valid),
    .conflict      (conflict_now),
    .busy_now      (busy_now),
    .idle_now      (idle_now),
    .conflict_total(conflict_total)
  );

  assert_single_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt == 2'b00) |-> !(fe_ready[0] && fe_ready[1]));
  assert_halt_silent_t0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt[0] |-> !(|(iss_valid & ~iss_thread)) && !fe_ready[0]);
  assert_halt_silent_t1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt[1] |-> !(|(iss_valid & iss_thread)) && !fe_ready[1]);
  assert_unit_code_t0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid[0] |-> fe_unit[1:0] != U_BAD);
  assert_unit_code_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid[1] |-> fe_unit[3:2] != U_BAD);
  assert_wb_t0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(iss_valid & ~iss_thread)) |=> wb_valid[0]);
  assert_wb_t1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(iss_valid & iss_thread)) |=> wb_valid[1]);
endmodule

// File: tb/test_smt_issue_arbiter.sv
`timescale 1ns/1ps
module test_smt_issue_arbiter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  halt = 2'b00, fe_valid = 2'b00, fe_ready;
  logic [3:0]  fe_unit = 4'h0;
  logic [15:0] fe_tag = 16'h0;
  logic [31:0] pc_out;
  logic [3:0]  iss_valid, iss_thread;
  logic [31:0] iss_tag;
  logic [1:0]  wb_valid;
  logic [15:0] wb_tag;
  logic [2:0]  busy_now, idle_now;
  logic        conflict_now;
  logic [15:0] conflict_total;

  logic [1:0]  d_halt = 2'b00, d_valid = 2'b00, d_ready;
  logic [3:0]  d_unit = 4'h0;
  logic [15:0] d_tag = 16'h0;
  logic [31:0] d_pc;
  logic [3:0]  d_iv, d_it;
  logic [31:0] d_itag;
  logic [1:0]  d_wbv;
  logic [15:0] d_wbt;
  logic [2:0]  d_busy, d_idle;
  logic        d_conf;
  logic [15:0] d_total;

  smt_issue_arbiter i_smt_issue_arbiter (
    .clk(clk), .rst_n(rst_n), .halt(halt), .fe_valid(fe_valid), .fe_ready(fe_ready),
    .fe_unit(fe_unit), .fe_tag(fe_tag), .pc_out(pc_out), .iss_valid(iss_valid),
    .iss_thread(iss_thread), .iss_tag(iss_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .busy_now(busy_now), .idle_now(idle_now), .conflict_now(conflict_now),
    .conflict_total(conflict_total));

  smt_issue_arbiter #(.DUAL_INT(1'b1)) i_smt_issue_arbiter_dual (
    .clk(clk), .rst_n(rst_n), .halt(d_halt), .fe_valid(d_valid), .fe_ready(d_ready),
    .fe_unit(d_unit), .fe_tag(d_tag), .pc_out(d_pc), .iss_valid(d_iv),
    .iss_thread(d_it), .iss_tag(d_itag), .wb_valid(d_wbv), .wb_tag(d_wbt),
    .busy_now(d_busy), .idle_now(d_idle), .conflict_now(d_conf),
    .conflict_total(d_total));

  // unit codes: 0 int, 1 fp, 2 load/store; iv/it bits: 0 int, 1 fp, 2 ls, 3 int twin
  typedef struct packed {
    logic [1:0] hlt; logic [1:0] fv; logic [1:0] u0; logic [1:0] u1;
    logic [1:0] rdy; logic [3:0] iv; logic [3:0] it; logic conf;
    logic [3:0] pc0; logic [3:0] pc1;
  } vec_t;

  localparam vec_t VEC [0:16] = '{
    '{2'b00, 2'b11, 2'd0, 2'd1, 2'b01, 4'b0000, 4'b0000, 1'b0, 4'd0, 4'd0},
    '{2'b00, 2'b11, 2'd2, 2'd1, 2'b10, 4'b0001, 4'b0000, 1'b0, 4'd1, 4'd0},
    '{2'b10, 2'b11, 2'd2, 2'd0, 2'b01, 4'b0000, 4'b0000, 1'b0, 4'd1, 4'd1},
    '{2'b10, 2'b11, 2'd1, 2'd0, 2'b01, 4'b0100, 4'b0000, 1'b0, 4'd2, 4'd1},
    '{2'b00, 2'b11, 2'd0, 2'd0, 2'b01, 4'b0010, 4'b0000, 1'b1, 4'd3, 4'd1},
    '{2'b00, 2'b11, 2'd2, 2'd2, 2'b10, 4'b0011, 4'b0010, 1'b0, 4'd4, 4'd1},
    '{2'b00, 2'b11, 2'd2, 2'd0, 2'b01, 4'b0100, 4'b0100, 1'b0, 4'd4, 4'd2},
    '{2'b00, 2'b11, 2'd0, 2'd2, 2'b10, 4'b0100, 4'b0000, 1'b0, 4'd5, 4'd2},
    '{2'b10, 2'b11, 2'd2, 2'd0, 2'b01, 4'b0000, 4'b0000, 1'b0, 4'd5, 4'd3},
    '{2'b00, 2'b11, 2'd1, 2'd0, 2'b10, 4'b0100, 4'b0100, 1'b1, 4'd6, 4'd3},
    '{2'b00, 2'b11, 2'd1, 2'd1, 2'b01, 4'b0101, 4'b0001, 1'b0, 4'd6, 4'd4},
    '{2'b00, 2'b00, 2'd0, 2'd0, 2'b10, 4'b0010, 4'b0000, 1'b0, 4'd7, 4'd4},
    '{2'b00, 2'b00, 2'd0, 2'd0, 2'b01, 4'b0000, 4'b0000, 1'b0, 4'd7, 4'd4},
    '{2'b11, 2'b11, 2'd0, 2'd0, 2'b00, 4'b0000, 4'b0000, 1'b0, 4'd7, 4'd4},
    '{2'b01, 2'b11, 2'd0, 2'd0, 2'b10, 4'b0000, 4'b0000, 1'b0, 4'd7, 4'd4},
    '{2'b01, 2'b11, 2'd0, 2'd1, 2'b10, 4'b0001, 4'b0001, 1'b0, 4'd7, 4'd5},
    '{2'b01, 2'b00, 2'd0, 2'd0, 2'b10, 4'b0010, 4'b0010, 1'b0, 4'd7, 4'd6}
  };

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check("R1", "fe_ready in reset", fe_ready, 2'b01);
    check("R1", "iss_valid in reset", iss_valid, 0);
    check("R1", "pc_out in reset", pc_out, 0);
    check("R1", "conflict_total in reset", conflict_total, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 17; i++) begin
      halt     = VEC[i].hlt;
      fe_valid = VEC[i].fv;
      fe_unit  = {VEC[i].u1, VEC[i].u0};
      fe_tag   = {8'(8'h20 + i), 8'(8'h10 + i)};
      #1;
      check("R2/R7/R9", $sformatf("fe_ready row %0d", i), fe_ready, VEC[i].rdy);
      check("R4/R5/R9", $sformatf("iss_valid row %0d", i), iss_valid, VEC[i].iv);
      check("R10", $sformatf("iss_thread row %0d", i), iss_thread & iss_valid, VEC[i].it);
      check("R5/R6", $sformatf("conflict_now row %0d", i), conflict_now, VEC[i].conf);
      check("R3", $sformatf("pc0 row %0d", i), pc_out[15:0], VEC[i].pc0);
      check("R3", $sformatf("pc1 row %0d", i), pc_out[31:16], VEC[i].pc1);
      check("R11", $sformatf("busy_now row %0d", i), busy_now, $countones(VEC[i].iv));
      check("R11", $sformatf("idle_now row %0d", i), idle_now, 3 - $countones(VEC[i].iv));
      if (i == 5) begin
        check("R4", "int tag row 5", iss_tag[7:0], 8'h14);
        check("R7", "retried fp tag row 5", iss_tag[15:8], 8'h21);
      end
      if (i == 10) begin
        check("R7", "retried ls tag row 10", iss_tag[23:16], 8'h18);
        check("R4", "int tag row 10", iss_tag[7:0], 8'h29);
      end
      @(negedge clk);
    end
    halt = 2'b00; fe_valid = 2'b00;
    #1;
    check("R10", "wb_valid after run", wb_valid, 2'b10);
    check("R10", "wb_tag thread0", wb_tag[7:0], 8'h1A);
    check("R10", "wb_tag thread1", wb_tag[15:8], 8'h2F);
    check("R11", "conflict_total after run", conflict_total, 2);

    // twin integer unit: both threads issue integer ops together
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    d_halt = 2'b00; d_valid = 2'b11; d_unit = 4'b0000; d_tag = 16'h4131;
    #1;
    check("R2", "dual fe_ready c0", d_ready, 2'b01);
    @(negedge clk);
    d_halt = 2'b01; d_valid = 2'b10; d_tag = 16'h4232;
    #1;
    check("R9", "dual fe_ready while t0 halted", d_ready, 2'b10);
    check("R9", "dual no issue while t0 halted", d_iv, 0);
    @(negedge clk);
    d_halt = 2'b00; d_valid = 2'b00;
    #1;
    check("R8", "dual iss_valid", d_iv, 4'b1001);
    check("R8", "dual iss_thread", d_it & d_iv, 4'b1000);
    check("R8", "dual conflict_now", d_conf, 0);
    check("R8", "dual int0 tag", d_itag[7:0], 8'h31);
    check("R8", "dual int1 tag", d_itag[31:24], 8'h42);
    check("R11", "dual busy_now", d_busy, 2);
    check("R11", "dual idle_now", d_idle, 2);
    @(negedge clk);
    #1;
    check("R10", "dual wb_valid", d_wbv, 2'b11);
    check("R10", "dual wb_tag", d_wbt, 16'h4231);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule